// File: doc/BRIEF.md
# I2C Client SCL Low-Time Watchdog

This block guards an I2C client against a bus whose clock line is held low for too long. It watches an already synchronized SCL level together with START and STOP strobes that an upstream bus decoder produces. It runs two independent time-outs. The continuous one measures how long SCL has been low without a break. The cumulative one adds up every low interval of SCL between a START and the next STOP. When either limit is reached, the block emits a one-cycle pulse that makes the client let go of any clock stretch and a one-cycle pulse that returns the client state machine to idle.

Time is measured in ticks. A free-running prescaler divides the system clock by a parameter so that one tick is one millisecond. A continuous low of 30 ticks is a violation, and so is a cumulative low of 26 ticks within one transaction. The block also keeps a stop-received flag. This flag is raised when a STOP closes a transaction in which the client's address matched and the cumulative limit was hit. A time-out never lowers this flag. Only the next START clears it.

Top module: `scl_lowtime_guard`

## Requirements
- R1: After reset, `hold_release`, `fsm_reset` and `stop_seen` are all 0.
- R2: With `lowto_en`=1, once SCL has been sampled low for CONT_TICKS consecutive ticks, `hold_release` and `fsm_reset` pulse together. The pulse comes between (CONT_TICKS-1)*TICK_DIV and CONT_TICKS*TICK_DIV+2 cycles after SCL falls.
- R3: A single sampled high level of SCL restarts the continuous count from zero.
- R4: Each time-out event produces exactly one pulse, one cycle wide, however long SCL then stays low. A new pulse needs the counter to be cleared first.
- R5: While its enable input is 0, a time-out never pulses. `lowto_en` gates the continuous check and `extto_en` gates the cumulative check.
- R6: With `extto_en`=1, ticks during which SCL is low are summed between START and STOP. The sum pauses while SCL is high. Both outputs pulse once when the sum reaches CUM_TICKS.
- R7: Every START, including a repeated one, and every STOP clears the cumulative sum. Outside a transaction, nothing is summed.
- R8: On a STOP, `stop_seen` goes to 1 on the next cycle only if `addr_hit` was seen since the last START and the cumulative time-out fired in that transaction. Otherwise it stays 0.
- R9: `stop_seen` is cleared only by a START. A time-out of either kind leaves it unchanged.
- R10: One tick is TICK_DIV clock cycles, counted by a free-running prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| start_i | input | 1 | One-cycle START or repeated START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| addr_hit_i | input | 1 | Strobe: client address matched |
| lowto_en | input | 1 | Enable for the continuous-low time-out |
| extto_en | input | 1 | Enable for the cumulative-low time-out |
| hold_release | output | 1 | One-cycle pulse: release clock stretch |
| fsm_reset | output | 1 | One-cycle pulse: reset client state machine |
| stop_seen | output | 1 | Stop-received flag after a cumulative time-out |

## Verification
The bench builds the block with TICK_DIV=4 and keeps the default tick limits of 30 and 26. A millisecond therefore lasts four clock cycles, and a full continuous time-out takes about 120 cycles. At that scale the bench can drive long SCL-low episodes, split lows across several phases, and run repeated STARTs in a few hundred cycles, while the real tick thresholds stay in place. Because the prescaler runs freely, its phase when SCL falls is unknown. The continuous latency is therefore checked against a one-tick window. For the cumulative case, low phases are made whole multiples of a tick, so the phase in which the pulse appears is exact.

// File: rtl/scl_guard_pkg.sv
package scl_guard_pkg;

    typedef struct packed {
        logic in_txn;
        logic addr_seen;
        logic ext_fired;
        logic stop_seen;
    } guard_state_t;

    function automatic int count_width(input int limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick_o = (div_q == LAST);

    // R10
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/scl_low_counter.sv
module scl_low_counter #(
    parameter int LIMIT      = 30,
    parameter bit CUMULATIVE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic scl_i,
    input  logic en_i,
    input  logic clear_i,
    input  logic active_i,
    output logic fire_o
);
    import scl_guard_pkg::*;

    localparam int W = count_width(LIMIT);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         fire;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic high_clr, clr;

    generate
        if (CUMULATIVE) begin : g_sum
            assign high_clr = 1'b0;
        end else begin : g_run
            assign high_clr = scl_i;
        end
    endgenerate

    assign clr = high_clr | clear_i | !en_i | !active_i;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick_i && !scl_i && st_q.cnt != TOP) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt + 1'b1 == TOP) st_d.fire = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = st_q.fire;

    // R4
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP);
    // R5
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(en_i));

endmodule

// File: rtl/scl_lowtime_guard.sv
module scl_lowtime_guard #(
    parameter int TICK_DIV   = 100000,
    parameter int CONT_TICKS = 30,
    parameter int CUM_TICKS  = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic addr_hit_i,
    input  logic lowto_en,
    input  logic extto_en,
    output logic hold_release,
    output logic fsm_reset,
    output logic stop_seen
);
    import scl_guard_pkg::*;

    logic tick, cont_fire, cum_fire, txn_edge;
    guard_state_t g_d, g_q;

    scl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    scl_low_counter #(.LIMIT(CONT_TICKS), .CUMULATIVE(1'b0)) u_cont (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .scl_i(scl_i),
        .en_i(lowto_en), .clear_i(1'b0), .active_i(1'b1), .fire_o(cont_fire)
    );

    assign txn_edge = start_i | stop_i;

    scl_low_counter #(.LIMIT(CUM_TICKS), .CUMULATIVE(1'b1)) u_cum (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .scl_i(scl_i),
        .en_i(extto_en), .clear_i(txn_edge), .active_i(g_q.in_txn),
        .fire_o(cum_fire)
    );

    always_comb begin
        g_d = g_q;
        if (start_i) begin
            g_d.in_txn    = 1'b1;
            g_d.addr_seen = addr_hit_i;
            g_d.ext_fired = 1'b0;
            g_d.stop_seen = 1'b0;
        end else if (stop_i) begin
            if (g_q.in_txn && (g_q.addr_seen || addr_hit_i) &&
                (g_q.ext_fired || cum_fire))
                g_d.stop_seen = 1'b1;
            g_d.in_txn    = 1'b0;
            g_d.addr_seen = 1'b0;
            g_d.ext_fired = 1'b0;
        end else begin
            if (addr_hit_i && g_q.in_txn) g_d.addr_seen = 1'b1;
            if (cum_fire)                 g_d.ext_fired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign hold_release = cont_fire | cum_fire;
    assign fsm_reset    = cont_fire | cum_fire;
    assign stop_seen    = g_q.stop_seen;

    // R8
    stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> $past(stop_i));
    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_seen) |-> $past(start_i));
    // R2
    pulse_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release == fsm_reset);

endmodule

// File: tb/scl_lowtime_guard_tb.sv
`timescale 1ns/1ps
module scl_lowtime_guard_tb;
    localparam int DIV = 4;
    localparam int CONT = 30;
    localparam int CUM = 26;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, start = 1'b0, stop = 1'b0, addr = 1'b0;
    logic lo_en = 1'b0, ext_en = 1'b0;
    logic hold_release, fsm_reset, stop_seen;

    int n_chk = 0, n_bad = 0, cyc = 0, pulses = 0, first_at = -1, mism = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scl_lowtime_guard #(.TICK_DIV(DIV), .CONT_TICKS(CONT), .CUM_TICKS(CUM)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .start_i(start), .stop_i(stop),
        .addr_hit_i(addr), .lowto_en(lo_en), .extto_en(ext_en),
        .hold_release(hold_release), .fsm_reset(fsm_reset), .stop_seen(stop_seen)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (hold_release) begin
            if (pulses == 0) first_at <= cyc;
            pulses <= pulses + 1;
        end
        if (hold_release != fsm_reset) mism <= mism + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_mon();
        @(negedge clk);
        pulses = 0; first_at = -1;
    endtask

    task automatic strobe_start(input logic a);
        @(negedge clk); start = 1'b1; addr = a;
        @(negedge clk); start = 1'b0; addr = 1'b0;
    endtask

    task automatic strobe_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 hold_release", hold_release, 0);
        check("R1 fsm_reset", fsm_reset, 0);
        check("R1 stop_seen", stop_seen, 0);
    endtask

    task automatic t_cont_fire();
        int t0, lat;
        lo_en = 1'b1; ext_en = 1'b0; scl = 1'b1;
        clr_mon();
        scl = 1'b0; t0 = cyc;
        wait_cyc(160);
        lat = first_at - t0;
        check("R2 pulse count in 160 cycles", pulses, 1);
        check("R2 latency window", int'(lat >= (CONT-1)*DIV && lat <= CONT*DIV + 2), 1);
        check("R2 pulses paired", mism, 0);
        wait_cyc(200);
        check("R4 single one-cycle pulse while SCL stays low", pulses, 1);
        scl = 1'b1; wait_cyc(2);
        clr_mon(); scl = 1'b0; wait_cyc(140);
        check("R4 new pulse after counter cleared", pulses, 1);
        scl = 1'b1; wait_cyc(2);
    endtask

    task automatic t_cont_break();
        lo_en = 1'b1; ext_en = 1'b0;
        clr_mon();
        scl = 1'b0; wait_cyc(100);
        scl = 1'b1; wait_cyc(1);
        scl = 1'b0; wait_cyc(100);
        check("R3 high level restarts continuous count", pulses, 0);
        scl = 1'b1; wait_cyc(2);
    endtask

    task automatic t_disabled();
        lo_en = 1'b0; ext_en = 1'b0;
        clr_mon();
        strobe_start(1'b0);
        scl = 1'b0; wait_cyc(300);
        check("R5 both disabled, no pulse", pulses, 0);
        scl = 1'b1;
        strobe_stop();
        wait_cyc(2);
    endtask

    task automatic cum_phases(input int n, input int low_c);
        for (int p = 0; p < n; p++) begin
            scl = 1'b0; wait_cyc(low_c);
            scl = 1'b1; wait_cyc(8);
        end
    endtask

    task automatic t_cum_fire(input logic with_addr, input int exp_stop);
        lo_en = 1'b1; ext_en = 1'b1;
        clr_mon();
        strobe_start(with_addr);
        cum_phases(2, 10*DIV);
        check("R6 no pulse before sum reaches limit", pulses, 0);
        cum_phases(1, 10*DIV);
        check("R6 one pulse in third low phase", pulses, 1);
        strobe_stop();
        check("R8 stop_seen after STOP", stop_seen, exp_stop);
    endtask

    task automatic t_stop_no_timeout();
        lo_en = 1'b1; ext_en = 1'b1;
        strobe_start(1'b1);
        check("R9 START clears stop_seen", stop_seen, 0);
        cum_phases(1, 5*DIV);
        strobe_stop();
        check("R8 no stop_seen without time-out", stop_seen, 0);
    endtask

    task automatic t_flag_kept();
        lo_en = 1'b1; ext_en = 1'b1;
        clr_mon();
        scl = 1'b0; wait_cyc(160);
        check("R9 continuous pulse fired", pulses, 1);
        check("R9 stop_seen kept through time-out", stop_seen, 1);
        scl = 1'b1; wait_cyc(2);
    endtask

    task automatic t_restart();
        lo_en = 1'b0; ext_en = 1'b1;
        clr_mon();
        strobe_start(1'b0);
        cum_phases(1, 15*DIV);
        strobe_start(1'b0);
        cum_phases(1, 15*DIV);
        check("R7 repeated START restarts sum", pulses, 0);
        strobe_stop();
        cum_phases(1, 15*DIV);
        strobe_start(1'b0);
        cum_phases(1, 12*DIV);
        check("R7 STOP clears, idle not summed", pulses, 0);
        strobe_stop();
    endtask

    task automatic t_cum_disabled();
        lo_en = 1'b0; ext_en = 1'b0;
        clr_mon();
        strobe_start(1'b1);
        cum_phases(3, 10*DIV);
        strobe_stop();
        check("R5 cumulative disabled, no pulse", pulses, 0);
        check("R5 cumulative disabled, no stop_seen", stop_seen, 0);
    endtask

    task automatic t_tick_rate();
        int t0, lat;
        lo_en = 1'b1; ext_en = 1'b0;
        clr_mon();
        scl = 1'b0; t0 = cyc;
        wait_cyc(CONT*DIV + 10);
        lat = first_at - t0;
        check("R10 tick lasts TICK_DIV cycles", int'(lat > (CONT-1)*DIV), 1);
        scl = 1'b1; wait_cyc(2);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_cont_fire();
        t_cont_break();
        t_disabled();
        t_cum_fire(1'b0, 0);
        t_cum_fire(1'b1, 1);
        t_flag_kept();
        t_stop_no_timeout();
        t_restart();
        t_cum_disabled();
        t_tick_rate();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule